// File: doc/BRIEF.md
# Systematic Encoder for a (15,7) Cyclic Geometry LDPC Code

This block turns a 7-bit data word into a 15-bit protected word of a cyclic low-density parity-check code built on a Euclidean geometry. The code has minimum distance 5. The data bits pass straight through into the low seven positions of the output. The upper eight positions carry check bits.

Each check bit comes from its own chain of 2-input XOR gates over a fixed subset of the data bits. No gate is shared between two check bits, so a single internal fault can upset at most one output bit. The subsets are not written out by hand. They are derived at elaboration from the code's generator polynomial, which is a parameter. They are the remainders of x^(8+i) divided by g(x) = 1 + x^4 + x^6 + x^7 + x^8.

A parameter selects between two variants. One is a registered variant with a valid strobe that follows the input strobe by one clock. The other is purely combinational.

Top module: `ldpc_sys_encoder`

## Requirements
- R1: Output bit i (0 to 6) equals data bit i of the captured word, so the data can be read without decoding.
- R2: Output bits 7 to 14 hold check bits 0 to 7. Check bit k is the XOR of every data bit i whose remainder x^(8+i) mod g(x) has coefficient k set. As a result, the output read as the polynomial c(x) = sum of c_j x^j is divisible by g(x) for all 128 data words.
- R3: Every output word has an all-zero syndrome against a 15x15 check matrix whose rows are the 15 cyclic shifts of one weight-4 row orthogonal to the code.
- R4: The smallest Hamming weight among the 127 non-zero output words is exactly 5.
- R5: The check bits use disjoint gate chains. Their data-bit subsets hold 30 members in total, which gives 22 two-input XOR gates, and every subset has at least 2 members.
- R6: With the registered variant (REGISTERED=1, the default), out_valid is high in exactly the cycle after a cycle in which in_valid was high.
- R7: With the registered variant, the output word is loaded only when in_valid is high. While in_valid is low it holds its value whatever info_i does.
- R8: An active-low asynchronous reset clears out_valid and the output word to zero at once. The zero word is itself a codeword.
- R9: With REGISTERED=0, out_valid follows in_valid and code_o is the encoding of info_i in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The data word on info_i is to be encoded |
| info_i | input | 7 | Data word to encode |
| out_valid | output | 1 | code_o carries a freshly encoded word |
| code_o | output | 15 | Protected word: data in bits 6:0, check bits in 14:7 |

## Verification
In the registered variant, the encoded word and its strobe appear at the first rising edge after the inputs are driven. The bench drives on falling edges and samples at the next falling edge, half a period after that capture. The combinational variant shares the same inputs and is sampled 1 ns after each drive, before any clock edge. Reset clearing is checked 1 ns after reset falls, with no edge in between. The checks on code structure (syndrome, distance, gate count) are run on the words the registered variant produced during a sweep of all 128 data values.

// File: rtl/ldpc_enc_pkg.sv
`timescale 1ns/1ps
package ldpc_enc_pkg;

    // Default code geometry: (15,7) cyclic code, 8 check bits.
    localparam int          DEF_INFO_W = 7;
    localparam int          DEF_PAR_W  = 8;
    // g(x) = 1 + x^4 + x^6 + x^7 + x^8, bit j holds the x^j coefficient.
    localparam logic [31:0] DEF_GEN    = 32'h0000_01D1;

    // x^e mod g(x), for a generator of degree par_w.
    function automatic logic [31:0] pow_mod(input logic [31:0] gen,
                                            input int          par_w,
                                            input int          e);
        logic [31:0] r;
        logic        top;
        r = 32'd1;
        for (int t = 0; t < e; t++) begin
            top = r[par_w-1];
            r   = (r << 1) & ((32'd1 << par_w) - 32'd1);
            if (top) begin
                r = r ^ (gen & ((32'd1 << par_w) - 32'd1));
            end
        end
        return r;
    endfunction

    // Data bits feeding check bit k: bit i set when x^(par_w+i) mod g has x^k.
    function automatic logic [31:0] check_subset(input logic [31:0] gen,
                                                 input int          info_w,
                                                 input int          par_w,
                                                 input int          k);
        logic [31:0] m;
        logic [31:0] rem;
        m = '0;
        for (int i = 0; i < info_w; i++) begin
            rem  = pow_mod(gen, par_w, par_w + i);
            m[i] = rem[k];
        end
        return m;
    endfunction

    function automatic int ones32(input logic [31:0] v);
        int n;
        n = 0;
        for (int b = 0; b < 32; b++) begin
            n = n + int'(v[b]);
        end
        return n;
    endfunction

    // Position of the n-th set bit of v (counting from 0).
    function automatic int nth_one(input logic [31:0] v, input int n);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int b = 0; b < 32; b++) begin
            if (v[b]) begin
                if (cnt == n) begin
                    pos = b;
                end
                cnt = cnt + 1;
            end
        end
        return pos;
    endfunction

    // Remainder of the word polynomial c(x) divided by g(x).
    function automatic logic [31:0] word_mod(input logic [31:0] c,
                                             input int          code_w,
                                             input logic [31:0] gen,
                                             input int          par_w);
        logic [31:0] r;
        r = c;
        for (int d = code_w - 1; d >= par_w; d--) begin
            if (r[d]) begin
                r = r ^ (gen << (d - par_w));
            end
        end
        return r & ((32'd1 << par_w) - 32'd1);
    endfunction

endpackage

// File: rtl/ldpc_xor_chain.sv
`timescale 1ns/1ps
// One check bit: a private chain of 2-input XOR gates over N_IN inputs.
module ldpc_xor_chain #(
    parameter int N_IN = 3
) (
    input  logic [N_IN-1:0] sel_i,
    output logic            par_o
);

    generate
        for (genvar j = 0; j < N_IN; j++) begin : g_link
            logic node;
            if (j == 0) begin : g_head
                assign node = sel_i[0];
            end else begin : g_xor
                assign node = g_link[j-1].node ^ sel_i[j];
            end
        end
    endgenerate

    assign par_o = g_link[N_IN-1].node;

endmodule

// File: rtl/ldpc_check_bank.sv
`timescale 1ns/1ps
// All check bits, one independent chain each; subsets come from g(x).
module ldpc_check_bank #(
    parameter int          INFO_W   = ldpc_enc_pkg::DEF_INFO_W,
    parameter int          PAR_W    = ldpc_enc_pkg::DEF_PAR_W,
    parameter logic [31:0] GEN_POLY = ldpc_enc_pkg::DEF_GEN
) (
    input  logic [INFO_W-1:0] info_i,
    output logic [PAR_W-1:0]  check_o
);

    generate
        for (genvar k = 0; k < PAR_W; k++) begin : g_check
            localparam logic [31:0] SUBSET =
                ldpc_enc_pkg::check_subset(GEN_POLY, INFO_W, PAR_W, k);
            localparam int N_SEL = ldpc_enc_pkg::ones32(SUBSET);

            if (N_SEL == 0) begin : g_none
                assign check_o[k] = 1'b0;
            end else begin : g_some
                logic [N_SEL-1:0] picked;
                for (genvar n = 0; n < N_SEL; n++) begin : g_pick
                    assign picked[n] = info_i[ldpc_enc_pkg::nth_one(SUBSET, n)];
                end
                ldpc_xor_chain #(
                    .N_IN (N_SEL)
                ) u_chain (
                    .sel_i (picked),
                    .par_o (check_o[k])
                );
            end
        end
    endgenerate

endmodule

// File: rtl/ldpc_out_stage.sv
`timescale 1ns/1ps
// Output stage: a register with a strobe, or a straight wire.
module ldpc_out_stage #(
    parameter int CODE_W     = 15,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              vld_o,
    output logic [CODE_W-1:0] code_o
);

    generate
        if (REGISTERED) begin : g_reg
            typedef struct packed {
                logic              vld;
                logic [CODE_W-1:0] code;
            } stage_t;

            stage_t stage_d;
            stage_t stage_q;

            always_comb begin
                stage_d     = stage_q;
                stage_d.vld = vld_i;
                if (vld_i) begin
                    stage_d.code = code_i;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= stage_d;
                end
            end

            assign vld_o  = stage_q.vld;
            assign code_o = stage_q.code;
        end else begin : g_wire
            assign vld_o  = vld_i;
            assign code_o = code_i;
        end
    endgenerate

endmodule

// File: rtl/ldpc_sys_encoder.sv
`timescale 1ns/1ps
// Systematic encoder for the (15,7) cyclic geometry LDPC code.
module ldpc_sys_encoder #(
    parameter int          INFO_W     = ldpc_enc_pkg::DEF_INFO_W,
    parameter int          PAR_W      = ldpc_enc_pkg::DEF_PAR_W,
    parameter logic [31:0] GEN_POLY   = ldpc_enc_pkg::DEF_GEN,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [INFO_W-1:0]         info_i,
    output logic                      out_valid,
    output logic [INFO_W+PAR_W-1:0]   code_o
);

    localparam int CODE_W = INFO_W + PAR_W;

    logic [PAR_W-1:0]  check_w;
    logic [CODE_W-1:0] code_w;

    ldpc_check_bank #(
        .INFO_W   (INFO_W),
        .PAR_W    (PAR_W),
        .GEN_POLY (GEN_POLY)
    ) u_bank (
        .info_i  (info_i),
        .check_o (check_w)
    );

    // Data in the low positions, check bits above them.
    assign code_w = {check_w, info_i};

    ldpc_out_stage #(
        .CODE_W     (CODE_W),
        .REGISTERED (REGISTERED)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_valid),
        .code_i (code_w),
        .vld_o  (out_valid),
        .code_o (code_o)
    );

endmodule

// File: rtl/ldpc_sys_encoder_chk.sv
`timescale 1ns/1ps
module ldpc_sys_encoder_chk #(
    parameter int          INFO_W     = ldpc_enc_pkg::DEF_INFO_W,
    parameter int          PAR_W      = ldpc_enc_pkg::DEF_PAR_W,
    parameter logic [31:0] GEN_POLY   = ldpc_enc_pkg::DEF_GEN,
    parameter bit          REGISTERED = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [INFO_W-1:0]       info_i,
    input logic                    out_valid,
    input logic [INFO_W+PAR_W-1:0] code_o
);

    localparam int CODE_W = INFO_W + PAR_W;

    logic [31:0] code_ext;
    logic [31:0] code_rem;

    assign code_ext = 32'(code_o);
    assign code_rem = ldpc_enc_pkg::word_mod(code_ext, CODE_W, GEN_POLY, PAR_W);

    AST_ALWAYS_CODEWORD: assert property (@(posedge clk) disable iff (!rst_n)
        code_rem == 32'd0) else $error("output is not a codeword"); // R2

    generate
        if (REGISTERED) begin : g_reg
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid) else $error("strobe missing"); // R6
            AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid) else $error("stray strobe"); // R6
            AST_DATA_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (code_o[INFO_W-1:0] == $past(info_i))) else $error("data bits"); // R1
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(code_o)) else $error("word changed while idle"); // R7
        end else begin : g_comb
            AST_COMB_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid) else $error("comb strobe"); // R9
            AST_COMB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                code_o[INFO_W-1:0] == info_i) else $error("comb data bits"); // R9
        end
    endgenerate

endmodule

bind ldpc_sys_encoder ldpc_sys_encoder_chk #(
    .INFO_W     (INFO_W),
    .PAR_W      (PAR_W),
    .GEN_POLY   (GEN_POLY),
    .REGISTERED (REGISTERED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .info_i    (info_i),
    .out_valid (out_valid),
    .code_o    (code_o)
);

// File: tb/sim_ldpc_sys_encoder.sv
`timescale 1ns/1ps
module sim_ldpc_sys_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  info = '0;
    logic        ov0, ov1;
    logic [14:0] code0, code1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [14:0] seen [0:127];
    logic [14:0] hrow;

    always #2.5 clk = ~clk;

    ldpc_sys_encoder u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .info_i (info),
        .out_valid (ov0), .code_o (code0)
    );

    ldpc_sys_encoder #(.REGISTERED(1'b0)) u1 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .info_i (info),
        .out_valid (ov1), .code_o (code1)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Bench reference: division by g(x) = 1 + x^4 + x^6 + x^7 + x^8.
    function automatic logic [7:0] rem15(input logic [14:0] c);
        logic [14:0] r;
        r = c;
        for (int d = 14; d >= 8; d--) begin
            if (r[d]) r = r ^ (15'h01D1 << (d - 8));
        end
        return r[7:0];
    endfunction

    // The unique word with these data bits whose polynomial g(x) divides.
    function automatic logic [14:0] ref_code(input logic [6:0] d);
        logic [14:0] c;
        logic [14:0] hit;
        hit = '0;
        for (int p = 255; p >= 0; p--) begin
            c = {p[7:0], d};
            if (rem15(c) == 8'd0) hit = c;
        end
        return hit;
    endfunction

    function automatic logic [14:0] rotl15(input logic [14:0] h, input int s);
        logic [29:0] t;
        t = {15'b0, h} << s;
        return t[14:0] | t[29:15];
    endfunction

    function automatic logic [14:0] syndrome(input logic [14:0] h, input logic [14:0] c);
        logic [14:0] s;
        for (int i = 0; i < 15; i++) s[i] = ^(rotl15(h, i) & c);
        return s;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; info = 7'h55;
        repeat (3) @(negedge clk);
        chk(ov0 == 1'b0, "R8", "strobe in reset", 32'(ov0), 0);
        chk(code0 == 15'h0, "R8", "word in reset", 32'(code0), 0);
        rst_n = 1'b1; in_valid = 1'b0;
    endtask

    task automatic check_reg(input int u);
        logic [14:0] e;
        e = ref_code(u[6:0]);
        chk(ov0 == 1'b1, "R6", "strobe one cycle later", 32'(ov0), 1);
        chk(code0 == e, "R2", "registered word", 32'(code0), 32'(e));
        chk(code0[6:0] == u[6:0], "R1", "data bits", 32'(code0[6:0]), 32'(u));
        seen[u] = code0;
    endtask

    task automatic t_sweep();
        logic [14:0] e;
        for (int v = 0; v < 128; v++) begin
            @(negedge clk);
            if (v > 0) check_reg(v - 1);
            in_valid = 1'b1; info = v[6:0];
            #1;
            e = ref_code(v[6:0]);
            chk(ov1 == 1'b1, "R9", "comb strobe", 32'(ov1), 1);
            chk(code1 == e, "R9", "comb word", 32'(code1), 32'(e));
        end
        @(negedge clk);
        check_reg(127);
        in_valid = 1'b0;
    endtask

    task automatic t_syndrome();
        bit found;
        bit ok;
        int bad;
        found = 1'b0;
        hrow = '0;
        for (int h = 1; h < 32768; h++) begin
            if (!found && $countones(h[14:0]) == 4) begin
                ok = 1'b1;
                for (int i = 0; i < 7; i++) begin
                    if (syndrome(h[14:0], ref_code(7'(1 << i))) != 15'h0) ok = 1'b0;
                end
                if (ok) begin
                    found = 1'b1;
                    hrow = h[14:0];
                end
            end
        end
        chk(found, "R3", "weight-4 check row exists", 32'(found), 1);
        bad = 0;
        for (int v = 0; v < 128; v++) begin
            if (syndrome(hrow, seen[v]) != 15'h0) bad++;
        end
        chk(bad == 0, "R3", "words with non-zero syndrome", bad, 0);
    endtask

    task automatic t_distance();
        int minw;
        minw = 15;
        for (int v = 1; v < 128; v++) begin
            if ($countones(seen[v]) < minw) minw = $countones(seen[v]);
        end
        chk(minw == 5, "R4", "minimum weight", minw, 5);
    endtask

    task automatic t_gates();
        int total;
        int colw;
        int thin;
        total = 0;
        thin = 0;
        for (int k = 0; k < 8; k++) begin
            colw = 0;
            for (int i = 0; i < 7; i++) colw += int'(seen[1 << i][7 + k]);
            if (colw < 2) thin++;
            total += colw;
        end
        chk(thin == 0, "R5", "check bits with fewer than 2 inputs", thin, 0);
        chk(total - 8 == 22, "R5", "two-input XOR count", total - 8, 22);
    endtask

    task automatic t_hold();
        logic [14:0] e;
        @(negedge clk);
        in_valid = 1'b1; info = 7'h2A;
        e = ref_code(7'h2A);
        @(negedge clk);
        chk(code0 == e, "R7", "load before idle", 32'(code0), 32'(e));
        in_valid = 1'b0;
        for (int n = 0; n < 4; n++) begin
            info = 7'(7'h13 * (n + 1));
            @(negedge clk);
            chk(ov0 == 1'b0, "R7", "no strobe when idle", 32'(ov0), 0);
            chk(code0 == e, "R7", "word held when idle", 32'(code0), 32'(e));
        end
    endtask

    task automatic t_pulse();
        @(negedge clk);
        in_valid = 1'b1; info = 7'h7F;
        @(negedge clk);
        chk(ov0 == 1'b1, "R6", "pulse seen", 32'(ov0), 1);
        in_valid = 1'b0;
        @(negedge clk);
        chk(ov0 == 1'b0, "R6", "pulse ends", 32'(ov0), 0);
    endtask

    task automatic t_midreset();
        @(negedge clk);
        in_valid = 1'b1; info = 7'h40;
        @(negedge clk);
        chk(ov0 == 1'b1, "R6", "strobe before reset", 32'(ov0), 1);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(ov0 == 1'b0, "R8", "async clear strobe", 32'(ov0), 0);
        chk(code0 == 15'h0, "R8", "async clear word", 32'(code0), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_syndrome();
        t_distance();
        t_gates();
        t_hold();
        t_pulse();
        t_midreset();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule